// File: doc/BRIEF.md
# Oversampled Serial Receiver with Start-Bit Qualification

This block recovers asynchronous serial characters from a single input line. It looks at the line once per strobe of a sampling enable that runs at sixteen times the bit rate. While idle it hunts for a falling edge that follows a settled high line. It then confirms the candidate start bit with a three-sample majority, so that short glitches do not launch a false character. After that it recovers each data bit, least significant first, from three samples taken near the bit centre. When a data bit voted 1 is followed by a bit voted 0, the measured position of that falling edge re-phases the bit-timing counter. This lets the block follow a transmitter whose bit rate is slightly slower than the local one.

Each finished character is placed in a holding register and a full flag is raised. The holding register also keeps a noise indication and a framing indication that belong to that character. A one-cycle read strobe from the host empties the holding register. An interrupt request follows the full flag whenever the host has enabled it. A character that completes while the register is still full is dropped, and an overrun flag is raised instead.

Top module: `os_serial_rx`

## Requirements
- R1: After reset, and after any period with the line low, a start bit is only recognised on a tick that samples 0 when the three previous ticks all sampled 1.
- R2: Counting the tick of the falling edge as tick 1, the start bit is sampled at ticks 3, 5 and 7. Write the samples as (t3,t5,t7). The start bit is accepted when at most one of the three is 1 (000, 001, 010, 100). With two or more 1s (011, 101, 110, 111) no character is received and the block returns to hunting.
- R3: An accepted start bit whose three samples are not all equal (001, 010, 100) sets the noise flag of that character. The pattern 000 does not set it. A rejected start bit leaves the noise flag unchanged.
- R4: Each data bit is the majority of the samples at ticks 8, 9 and 10 of its bit period. Bits are assembled least significant first. Any disagreement among the three samples of a data bit or of the stop bit sets the noise flag of that character.
- R5: When a data bit votes 1 and the next data bit votes 0, the tick counter is re-phased to the falling edge seen between them. A character sent with 17 ticks per bit and alternating bits is then received without error.
- R6: A stop bit that votes 0 sets the framing flag of that character. A stop bit that votes 1 clears it.
- R7: When the stop bit has been voted and the holding register is empty, the data, noise and framing values are loaded into it and rx_full goes to 1.
- R8: irq is 1 exactly while rx_full and irq_en are both 1.
- R9: A one-cycle pulse on rd_strobe clears rx_full and overrun.
- R10: If a character completes while rx_full is 1, overrun goes to 1 and rx_data, noise_flag and frame_err keep the earlier character.
- R11: After reset, rx_data is 0 and rx_full, irq, noise_flag, frame_err and overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Raw serial line, idle high |
| rd_strobe | input | 1 | Host read of the holding register |
| irq_en | input | 1 | Receive interrupt enable |
| rx_data | output | DATA_BITS (8) | Last received character |
| rx_full | output | 1 | Holding register contains an unread character |
| irq | output | 1 | Receive interrupt request |
| noise_flag | output | 1 | Some sample vote of the held character was split |
| frame_err | output | 1 | The held character had a low stop bit |
| overrun | output | 1 | A character was lost because the register was full |

## Verification
The assertions assume that tick is high for single clock cycles, several clocks apart. They also assume that rd_strobe is a one-cycle pulse. The line is assumed to change at most once between ticks and to settle through the synchroniser before the next tick, so each line value is seen by exactly one sample. The stimulus drives one line value per sampling slot, changes rxd right after the previous tick, and raises tick only after the synchroniser delay has passed. Glitches, start-bit patterns and a stretched 17-tick bit period are built from that same per-slot discipline.

// File: rtl/os_rx_pkg.sv
package os_rx_pkg;

   typedef enum logic [1:0] {
      ST_HUNT,
      ST_START,
      ST_DATA,
      ST_STOP
   } rx_state_e;

   function automatic logic maj3(input logic [2:0] v);
      return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
   endfunction

   function automatic logic split3(input logic [2:0] v);
      return (v != 3'b000) && (v != 3'b111);
   endfunction

endpackage

// File: rtl/os_rx_sync.sv
module os_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '1;
            end else begin
               q[0] <= din;
               for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
            end
         end
         assign dout = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/os_rx_hunt.sv
module os_rx_hunt (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line,
   output logic start_seen,
   output logic prev_s
);

   logic [2:0] hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hist <= 3'b000;
      else if (tick) hist <= {hist[1:0], line};
   end

   assign start_seen = tick && (hist == 3'b111) && !line;
   assign prev_s     = hist[0];

endmodule

// File: rtl/os_rx_frame.sv
module os_rx_frame
   import os_rx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int DATA_BITS  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 line,
   input  logic                 start_seen,
   input  logic                 prev_s,
   output logic                 done,
   output logic [DATA_BITS-1:0] byte_o,
   output logic                 noise_o,
   output logic                 ferr_o
);

   localparam int CW = $clog2(OVERSAMPLE + 1);
   localparam int BW = $clog2(DATA_BITS) + 1;
   localparam int V0 = OVERSAMPLE / 2;
   localparam int Q1 = 3;
   localparam int Q2 = 5;
   localparam int Q3 = 7;

   generate
      if (OVERSAMPLE < 12 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("os_rx_frame: OVERSAMPLE must be even and at least 12");
      end
      if (DATA_BITS < 2) begin : g_bad_db
         $error("os_rx_frame: DATA_BITS must be at least 2");
      end
   endgenerate

   rx_state_e            st;
   logic [CW-1:0]        cnt, cur, edge_at;
   logic [1:0]           smp;
   logic                 voted, eseen, prev_bit;
   logic [DATA_BITS-1:0] shreg;
   logic [BW-1:0]        bitn;
   logic                 nacc;

   logic                 wrap, voted_eff, eseen_eff, in_bits;
   logic [2:0]           trio;
   logic                 vbit, vsplit, vote_now, grab_edge, resync;

   always_comb begin
      cur       = (cnt == CW'(OVERSAMPLE)) ? CW'(1) : cnt + CW'(1);
      wrap      = (cur == CW'(1));
      voted_eff = voted && !wrap;
      eseen_eff = eseen && !wrap;
      in_bits   = (st == ST_DATA) || (st == ST_STOP);
      trio      = {smp[0], smp[1], line};
      vbit      = maj3(trio);
      vsplit    = split3(trio);
      vote_now  = in_bits && (cur == CW'(V0 + 2)) && !voted_eff;
      grab_edge = in_bits && !voted_eff && !eseen_eff && prev_bit &&
                  prev_s && !line && (cur < CW'(V0));
      resync    = vote_now && prev_bit && !vbit && eseen_eff;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_HUNT;
         cnt      <= '0;
         edge_at  <= '0;
         smp      <= '0;
         voted    <= 1'b0;
         eseen    <= 1'b0;
         prev_bit <= 1'b0;
         shreg    <= '0;
         bitn     <= '0;
         nacc     <= 1'b0;
         done     <= 1'b0;
         byte_o   <= '0;
         noise_o  <= 1'b0;
         ferr_o   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (st)
               ST_HUNT: begin
                  if (start_seen) begin
                     st   <= ST_START;
                     cnt  <= CW'(1);
                     nacc <= 1'b0;
                  end
               end
               ST_START: begin
                  cnt <= cur;
                  if (cur == CW'(Q1)) smp[0] <= line;
                  if (cur == CW'(Q2)) smp[1] <= line;
                  if (cur == CW'(Q3)) begin
                     if (vbit) st <= ST_HUNT;
                     else      nacc <= vsplit;
                  end
                  if (cur == CW'(OVERSAMPLE)) begin
                     st       <= ST_DATA;
                     bitn     <= '0;
                     voted    <= 1'b0;
                     eseen    <= 1'b0;
                     prev_bit <= 1'b0;
                  end
               end
               default: begin
                  cnt <= resync ? CW'(V0 + 3) - edge_at : cur;
                  if (wrap) begin
                     voted <= 1'b0;
                     eseen <= 1'b0;
                  end
                  if (grab_edge) begin
                     eseen   <= 1'b1;
                     edge_at <= cur;
                  end
                  if (cur == CW'(V0))     smp[0] <= line;
                  if (cur == CW'(V0 + 1)) smp[1] <= line;
                  if (vote_now) begin
                     voted    <= 1'b1;
                     prev_bit <= vbit;
                     if (st == ST_DATA) begin
                        shreg <= {vbit, shreg[DATA_BITS-1:1]};
                        nacc  <= nacc | vsplit;
                        bitn  <= bitn + BW'(1);
                        if (bitn == BW'(DATA_BITS - 1)) st <= ST_STOP;
                     end else begin
                        done    <= 1'b1;
                        byte_o  <= shreg;
                        noise_o <= nacc | vsplit;
                        ferr_o  <= !vbit;
                        st      <= ST_HUNT;
                     end
                  end
               end
            endcase
         end
      end
   end

   // R1: a qualified edge from the hunter always opens a start-bit window
   assert_hunt_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HUNT && start_seen) |=> (st == ST_START));

   // R7: completion is a single-cycle event
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/os_rx_hold.sv
module os_rx_hold #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] ld_data,
   input  logic                 ld_noise,
   input  logic                 ld_ferr,
   input  logic                 rd,
   input  logic                 irq_en,
   output logic [DATA_BITS-1:0] data,
   output logic                 full,
   output logic                 noise,
   output logic                 ferr,
   output logic                 overrun,
   output logic                 irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data    <= '0;
         full    <= 1'b0;
         noise   <= 1'b0;
         ferr    <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (rd) begin
            full    <= 1'b0;
            overrun <= 1'b0;
         end
         if (load) begin
            if (full && !rd) begin
               overrun <= 1'b1;
            end else begin
               data  <= ld_data;
               noise <= ld_noise;
               ferr  <= ld_ferr;
               full  <= 1'b1;
            end
         end
      end
   end

   assign irq = full & irq_en;

   assert_load_sets_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> full);

   assert_overrun_keeps_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load && full && !rd) |=> (overrun && $stable(data)));

   assert_read_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !load) |=> (!full && !overrun));

   assert_irq_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> full);

endmodule

// File: rtl/os_serial_rx.sv
module os_serial_rx #(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 rxd,
   input  logic                 rd_strobe,
   input  logic                 irq_en,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_full,
   output logic                 irq,
   output logic                 noise_flag,
   output logic                 frame_err,
   output logic                 overrun
);

   logic                 line, start_seen, prev_s;
   logic                 done, f_noise, f_ferr;
   logic [DATA_BITS-1:0] f_byte;

   os_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rst_n (rst_n),
      .din (rxd),
      .dout (line)
   );

   os_rx_hunt i_hunt (
      .clk (clk),
      .rst_n (rst_n),
      .tick (tick),
      .line (line),
      .start_seen (start_seen),
      .prev_s (prev_s)
   );

   os_rx_frame #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) i_frame (
      .clk (clk),
      .rst_n (rst_n),
      .tick (tick),
      .line (line),
      .start_seen (start_seen),
      .prev_s (prev_s),
      .done (done),
      .byte_o (f_byte),
      .noise_o (f_noise),
      .ferr_o (f_ferr)
   );

   os_rx_hold #(.DATA_BITS(DATA_BITS)) i_hold (
      .clk (clk),
      .rst_n (rst_n),
      .load (done),
      .ld_data (f_byte),
      .ld_noise (f_noise),
      .ld_ferr (f_ferr),
      .rd (rd_strobe),
      .irq_en (irq_en),
      .data (rx_data),
      .full (rx_full),
      .noise (noise_flag),
      .ferr (frame_err),
      .overrun (overrun),
      .irq (irq)
   );

endmodule

// File: tb/test_os_serial_rx.sv
`timescale 1ns/1ps
module test_os_serial_rx;

   logic       clk = 1'b0;
   logic       rst_n, tick, rxd, rd_strobe, irq_en;
   logic [7:0] rx_data;
   logic       rx_full, irq, noise_flag, frame_err, overrun;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   os_serial_rx i_os_serial_rx (
      .clk (clk), .rst_n (rst_n), .tick (tick), .rxd (rxd),
      .rd_strobe (rd_strobe), .irq_en (irq_en), .rx_data (rx_data),
      .rx_full (rx_full), .irq (irq), .noise_flag (noise_flag),
      .frame_err (frame_err), .overrun (overrun)
   );

   typedef struct packed {
      logic [7:0] data;
      logic [2:0] pat;     // start samples (t3,t5,t7)
      logic [7:0] glitch;  // frame slot to invert, 255 = none
      logic [4:0] blen;    // ticks per bit
      logic       stopv;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{8'hA5, 3'b000, 8'd255, 5'd16, 1'b1},
      '{8'h5A, 3'b011, 8'd255, 5'd16, 1'b1},
      '{8'hC3, 3'b101, 8'd255, 5'd16, 1'b1},
      '{8'h96, 3'b110, 8'd255, 5'd16, 1'b1},
      '{8'h69, 3'b111, 8'd255, 5'd16, 1'b1},
      '{8'h3C, 3'b001, 8'd255, 5'd16, 1'b1},
      '{8'h00, 3'b010, 8'd255, 5'd16, 1'b1},
      '{8'hFF, 3'b100, 8'd255, 5'd16, 1'b1},
      '{8'h81, 3'b000, 8'd55,  5'd16, 1'b1},
      '{8'h55, 3'b000, 8'd255, 5'd17, 1'b1},
      '{8'h0F, 3'b000, 8'd255, 5'd16, 1'b0},
      '{8'hE7, 3'b000, 8'd153, 5'd16, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one sampling slot: drive the line, let it settle, then one tick
   task automatic slot(input logic v);
      @(negedge clk); rxd = v; tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) slot(1'b1);
   endtask

   task automatic host_read();
      @(negedge clk); rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic lineval(input vec_t v, input int i);
      int   idx, off;
      logic b;
      idx = i / int'(v.blen);
      off = i % int'(v.blen);
      if (idx == 0) begin
         if (off == 2)      b = v.pat[2];
         else if (off == 4) b = v.pat[1];
         else if (off == 6) b = v.pat[0];
         else               b = 1'b0;
      end else if (idx <= 8) b = v.data[idx-1];
      else                   b = v.stopv;
      if (v.glitch != 8'd255 && i == int'(v.glitch)) b = ~b;
      return b;
   endfunction

   task automatic send(input vec_t v, input int nslots);
      for (int i = 0; i < nslots; i++) slot(lineval(v, i));
   endtask

   task automatic clean(input logic [7:0] d);
      vec_t v;
      v = '{d, 3'b000, 8'd255, 5'd16, 1'b1};
      send(v, 160);
      idle(8);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog (R7) actual=hung expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic last_noise;
      rst_n = 1'b0; tick = 1'b0; rxd = 1'b1; rd_strobe = 1'b0; irq_en = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      chk("R11 rx_data", rx_data, 8'h00);
      chk("R11 rx_full", rx_full, 0);
      chk("R11 irq", irq, 0);
      chk("R11 noise", noise_flag, 0);
      chk("R11 frame_err", frame_err, 0);
      chk("R11 overrun", overrun, 0);

      idle(20);
      last_noise = 1'b0;
      for (int k = 0; k < NV; k++) begin
         vec_t v;
         logic acc, en;
         v   = VECS[k];
         acc = ($countones(v.pat) <= 1);
         en  = (v.pat != 3'b000) || (v.glitch != 8'd255);
         if (acc) begin
            send(v, 10 * int'(v.blen));
            idle(8);
            chk("R7 full after character", rx_full, 1);
            chk("R4/R5 data", rx_data, v.data);
            chk("R3/R4 noise", noise_flag, en);
            chk("R6 frame_err", frame_err, !v.stopv);
            chk("R8 irq with enable", irq, 1);
            chk("R10 no overrun", overrun, 0);
            last_noise = en;
            host_read();
            chk("R9 read clears full", rx_full, 0);
         end else begin
            send(v, 7);
            idle(8);
            chk("R2 rejected start", rx_full, 0);
            chk("R3 noise unchanged on reject", noise_flag, last_noise);
         end
      end

      // R8: enable gates the request
      irq_en = 1'b0;
      clean(8'h42);
      chk("R8 irq masked", irq, 0);
      chk("R7 full", rx_full, 1);
      @(negedge clk); irq_en = 1'b1;
      @(negedge clk);
      chk("R8 irq unmasked", irq, 1);
      host_read();
      chk("R8 irq drops after read", irq, 0);

      // R10: overrun keeps first character
      clean(8'h12);
      clean(8'h34);
      chk("R10 overrun set", overrun, 1);
      chk("R10 data kept", rx_data, 8'h12);
      chk("R10 still full", rx_full, 1);
      host_read();
      chk("R9 full cleared", rx_full, 0);
      chk("R9 overrun cleared", overrun, 0);

      // R6: line held low -> character with low stop bit
      for (int i = 0; i < 200; i++) slot(1'b0);
      chk("R6 frame_err on low stop", frame_err, 1);
      chk("R6 data of low line", rx_data, 8'h00);
      host_read();

      // R1: only two high samples before the fall -> no start
      slot(1'b1); slot(1'b1);
      for (int i = 0; i < 160; i++) slot(1'b0);
      idle(20);
      chk("R1 no start without three 1s", rx_full, 0);

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule